// File: doc/BRIEF.md
# Multiplier-Resolution CPU Watchdog

This block supervises a processor by expecting periodic accesses to a single 8-bit control register. The register carries a steering bit, a 5-bit multiplier and a 2-bit resolution code. The block counts ticks of a fixed 1/16 s time base. When the multiplier times the selected resolution elapses with no access to the register, the watchdog expires. Any read or write of the register starts the period again.

The steering bit picks what happens at expiry. With steering clear, a sticky flag is set and drives the interrupt line. The flag stays set until software reads the flag byte or accesses the control register. With steering set, the block emits a reset pulse of a fixed number of ticks. It also wipes the control register, which disarms the watchdog, and asks the neighbouring frequency-test bit to clear.

The interrupt line is shared with a frequency-test square wave. The wave gets through only when the watchdog is not steered to the interrupt. The open-drain pad drivers and the supply monitor belong to the surrounding chip.

Top module: `wdog_top`

## Requirements
- R1: A write stores the whole byte, and `cfgRdData` returns it. The fields are: bit 7 is the steering bit, bits 6..2 are the multiplier, and bits 1..0 are the resolution code.
- R2: The resolution codes 0, 1, 2 and 3 weigh 1, 4, 16 and 64 ticks. Expiry happens on the (multiplier × weight)-th tick after the last register access.
- R3: Any read or write of the control register restarts the count from zero.
- R4: A multiplier of zero disarms the watchdog, whatever the other bits hold. It never expires, so the flag, the interrupt and the reset all stay low.
- R5: Power-up reset clears the register, the flag, the reset pulse and the clear request.
- R6: With the steering bit at 0, expiry sets `wdFlag` and `wdIrq`. Both stay set until a flag-byte read or a control-register read or write takes place.
- R7: With the steering bit at 1, expiry raises `cpuRst` for exactly PULSE_TICKS ticks and leaves `wdFlag` clear.
- R8: An expiry with the steering bit at 1 clears the register to 00h and gives a one-cycle `ftBitClr` pulse.
- R9: `wdIrq` is high while the flag is set. Otherwise it follows `ftWave`, but only if `ftActive` is high and either the steering bit is 1 or the register is 00h. In every other case it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| tickEn | input | 1 | One-cycle pulse every 1/16 s |
| regWrEn | input | 1 | Control register write strobe |
| regRdEn | input | 1 | Control register read strobe |
| regWrData | input | 8 | Write data for the control register |
| flagRdEn | input | 1 | Flag byte read strobe |
| ftActive | input | 1 | Frequency-test output requested |
| ftWave | input | 1 | Frequency-test square wave |
| cfgRdData | output | 8 | Current control register contents |
| wdFlag | output | 1 | Watchdog expiry flag |
| wdIrq | output | 1 | Shared interrupt / frequency-test line |
| cpuRst | output | 1 | Reset pulse, active high |
| ftBitClr | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
The assertions are checked on every cycle. They cover the following:
- the flag holds until one of the three access kinds clears it;
- a register access always leaves the flag clear;
- a reset pulse starts only with an armed multiplier, and it starts together with a wiped register;
- the pulse never ends between ticks;
- the interrupt line obeys the flag and the frequency-test gating.

Only the bench scenarios can show the exact expiry tick for each resolution and multiplier, the restart on a read, the pulse length and behaviour over long disarmed runs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // clear the period counter
    logic cfgLoad;  // capture write data into the register
    logic cfgWipe;  // clear the register after a reset-steered expiry
  } dpCtrl_t;

  typedef enum logic {
    PULSE_IDLE = 1'b0,
    PULSE_ON   = 1'b1
  } pulseState_t;

endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int CFG_W   = 1 + MULT_W + RES_W,
  localparam int NUM_RES = 1 << RES_W,
  localparam int CNT_W   = MULT_W + 2 * (NUM_RES - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpCtrl_t          dpCtrl,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgQ,
  output logic             expireHit,
  output logic             steerRst
);

  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  resSel;
  logic              armed;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  scaled [NUM_RES];

  assign mult     = cfgQ[CFG_W-2:RES_W];
  assign resSel   = cfgQ[RES_W-1:0];
  assign steerRst = cfgQ[CFG_W-1];
  assign armed    = (mult != '0);

  // each resolution step is four times the previous one
  for (genvar k = 0; k < NUM_RES; k++) begin : g_scale
    assign scaled[k] = CNT_W'(mult) << (2 * k);
  end

  assign limit = scaled[resSel];

  assign expireHit = armed && tickEn && !dpCtrl.restart &&
                     (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (dpCtrl.cfgLoad) begin
      cfgQ <= wrData;
    end else if (dpCtrl.cfgWipe) begin
      cfgQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (dpCtrl.restart || dpCtrl.cfgWipe || !armed) begin
      cnt <= '0;
    end else if (tickEn) begin
      cnt <= expireHit ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 2,
  localparam int PCNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    regWrEn,
  input  logic    regRdEn,
  input  logic    flagRdEn,
  input  logic    expireHit,
  input  logic    steerRst,
  output dpCtrl_t dpCtrl,
  output logic    wdFlag,
  output logic    cpuRst,
  output logic    ftBitClr
);

  pulseState_t      pState;
  logic [PCNT_W-1:0] pCnt;
  logic              fireIrq;
  logic              fireRst;
  logic              flagClr;

  assign fireIrq = expireHit && !steerRst;
  assign fireRst = expireHit && steerRst;
  assign flagClr = regWrEn || regRdEn || flagRdEn;

  always_comb begin
    dpCtrl.restart = regWrEn || regRdEn;
    dpCtrl.cfgLoad = regWrEn;
    dpCtrl.cfgWipe = fireRst;
  end

  // a new expiry wins over a flag-byte read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdFlag <= 1'b0;
    end else if (fireIrq) begin
      wdFlag <= 1'b1;
    end else if (flagClr) begin
      wdFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ftBitClr <= 1'b0;
    end else begin
      ftBitClr <= fireRst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pState <= PULSE_IDLE;
      pCnt   <= '0;
    end else if (fireRst) begin
      pState <= PULSE_ON;
      pCnt   <= '0;
    end else if (pState == PULSE_ON && tickEn) begin
      if (pCnt + PCNT_W'(1) == PCNT_W'(PULSE_TICKS)) begin
        pState <= PULSE_IDLE;
        pCnt   <= '0;
      end else begin
        pCnt <= pCnt + PCNT_W'(1);
      end
    end
  end

  assign cpuRst = (pState == PULSE_ON);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int MULT_W      = 5,
  parameter int RES_W       = 2,
  parameter int PULSE_TICKS = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      regWrEn,
  input  logic                      regRdEn,
  input  logic [MULT_W+RES_W:0]     regWrData,
  input  logic                      flagRdEn,
  input  logic                      ftActive,
  input  logic                      ftWave,
  output logic [MULT_W+RES_W:0]     cfgRdData,
  output logic                      wdFlag,
  output logic                      wdIrq,
  output logic                      cpuRst,
  output logic                      ftBitClr
);

  dpCtrl_t dpCtrl;
  logic    expireHit;
  logic    steerRst;
  logic    ftPermit;

  wdog_dp #(.MULT_W(MULT_W), .RES_W(RES_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .dpCtrl   (dpCtrl),
    .wrData   (regWrData),
    .cfgQ     (cfgRdData),
    .expireHit(expireHit),
    .steerRst (steerRst)
  );

  wdog_ctrl #(.PULSE_TICKS(PULSE_TICKS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .flagRdEn (flagRdEn),
    .expireHit(expireHit),
    .steerRst (steerRst),
    .dpCtrl   (dpCtrl),
    .wdFlag   (wdFlag),
    .cpuRst   (cpuRst),
    .ftBitClr (ftBitClr)
  );

  // interrupt-steered watchdog denies the frequency test
  assign ftPermit = steerRst || (cfgRdData == '0);
  assign wdIrq    = wdFlag || (ftActive && ftPermit && ftWave);

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CFG_W = 8,
  parameter int RES_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic             flagRdEn,
  input logic             ftActive,
  input logic [CFG_W-1:0] cfgRdData,
  input logic             wdFlag,
  input logic             wdIrq,
  input logic             cpuRst,
  input logic             ftBitClr
);

  // R5
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (cfgRdData == '0 && !wdFlag && !cpuRst && !ftBitClr));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdFlag && !regWrEn && !regRdEn && !flagRdEn) |=> wdFlag);

  // R6
  access_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |=> !wdFlag);

  // R4
  flag_needs_mult_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> ($past(cfgRdData[CFG_W-2:RES_W]) != '0));

  // R4
  pulse_needs_mult_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRst) |-> ($past(cfgRdData[CFG_W-2:RES_W]) != '0));

  // R8
  pulse_wipes_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRst) |-> (cfgRdData == '0 && ftBitClr));

  // R7
  pulse_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRst && !tickEn) |=> cpuRst);

  // R9
  flag_drives_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdFlag |-> wdIrq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wdFlag && !ftActive) |-> !wdIrq);

endmodule

bind wdog_top wdog_chk #(.CFG_W(MULT_W + RES_W + 1), .RES_W(RES_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .flagRdEn (flagRdEn),
  .ftActive (ftActive),
  .cfgRdData(cfgRdData),
  .wdFlag   (wdFlag),
  .wdIrq    (wdIrq),
  .cpuRst   (cpuRst),
  .ftBitClr (ftBitClr)
);

// File: tb/wdog_tb.sv
module wdog_top_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int PULSE_TICKS = 2;
  localparam int MAX_CYCLES  = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       flagRdEn = 1'b0;
  logic       ftActive = 1'b0;
  logic       ftWave = 1'b0;
  logic [7:0] cfgRdData;
  logic       wdFlag;
  logic       wdIrq;
  logic       cpuRst;
  logic       ftBitClr;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;

  wdog_top #(.MULT_W(5), .RES_W(2), .PULSE_TICKS(PULSE_TICKS)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .flagRdEn(flagRdEn),
    .ftActive(ftActive), .ftWave(ftWave), .cfgRdData(cfgRdData),
    .wdFlag(wdFlag), .wdIrq(wdIrq), .cpuRst(cpuRst), .ftBitClr(ftBitClr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > MAX_CYCLES) begin
      failCnt  = failCnt + 1;
      checkCnt = checkCnt + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cycles, MAX_CYCLES);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  function automatic int expTicks(input logic [7:0] cfg);
    return int'(cfg[6:2]) << (2 * int'(cfg[1:0]));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg();
    @(negedge clk); regRdEn = 1'b1;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic rdFlag();
    @(negedge clk); flagRdEn = 1'b1;
    @(negedge clk); flagRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R5 reset state
    check(cfgRdData == 8'h00 && !wdFlag && !cpuRst && !ftBitClr, "R5 reset", int'(cfgRdData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 layout / readback
    wrReg(8'hA7);
    check(cfgRdData == 8'hA7, "R1 readback", int'(cfgRdData), 8'hA7);
    wrReg(8'h00);

    // R4 zero multiplier disarmed, with steering and resolution set
    wrReg(8'h83);
    ticks(80);
    check(!wdFlag && !cpuRst && !wdIrq, "R4 disarmed 0x83", int'(cpuRst), 0);
    wrReg(8'h00);
    ticks(40);
    check(!wdFlag && !cpuRst, "R4 disarmed 0x00", int'(wdFlag), 0);

    // R2 example 0b00001110 -> 3 x 16 ticks
    wrReg(8'b00001110);
    ticks(expTicks(8'b00001110) - 1);
    check(!wdFlag, "R2 before 48", int'(wdFlag), 0);
    ticks(1);
    check(wdFlag && wdIrq, "R2 at 48 (R6 irq)", int'(wdFlag), 1);
    // R6 sticky
    ticks(5);
    check(wdFlag, "R6 sticky", int'(wdFlag), 1);
    rdFlag();
    check(!wdFlag && !wdIrq, "R6 flag read clears", int'(wdFlag), 0);

    // R2 coarsest resolution: 1 x 64 ticks
    wrReg(8'h07);
    ticks(63);
    check(!wdFlag, "R2 before 64", int'(wdFlag), 0);
    ticks(1);
    check(wdFlag, "R2 at 64", int'(wdFlag), 1);
    rdReg();
    check(!wdFlag, "R6 register read clears", int'(wdFlag), 0);
    wrReg(8'h04);
    ticks(1);
    check(wdFlag, "R2 1 tick", int'(wdFlag), 1);
    wrReg(8'h00);
    check(!wdFlag, "R6 write clears", int'(wdFlag), 0);

    // R3 read restarts
    wrReg(8'h08);            // 2 x 1 tick
    ticks(1);
    rdReg();
    ticks(1);
    check(!wdFlag, "R3 read restart", int'(wdFlag), 0);
    ticks(1);
    check(wdFlag, "R3 expiry after restart", int'(wdFlag), 1);
    wrReg(8'h00);

    // R7/R8 reset steering: 0x89 = steer, mult 2, res 1 -> 8 ticks
    wrReg(8'h89);
    ticks(7);
    check(!cpuRst, "R7 before expiry", int'(cpuRst), 0);
    ticks(1);
    check(cpuRst && !wdFlag, "R7 pulse starts", int'(cpuRst), 1);
    check(ftBitClr, "R8 ft clear pulse", int'(ftBitClr), 1);
    check(cfgRdData == 8'h00, "R8 register wiped", int'(cfgRdData), 0);
    @(negedge clk);
    check(!ftBitClr, "R8 ft clear one cycle", int'(ftBitClr), 0);
    ticks(PULSE_TICKS - 1);
    check(cpuRst, "R7 pulse holds", int'(cpuRst), 1);
    ticks(1);
    check(!cpuRst, "R7 pulse ends", int'(cpuRst), 0);
    ticks(40);
    check(!cpuRst && !wdFlag, "R8 stays disarmed", int'(cpuRst), 0);

    // R9 frequency-test gating
    ftActive = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ftWave = i[0];
      @(negedge clk);
      check(wdIrq == ftWave, "R9 ft pass at 00h", int'(wdIrq), int'(ftWave));
    end
    wrReg(8'h7C);            // steer irq, armed: ft denied
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ftWave = i[0];
      @(negedge clk);
      check(!wdIrq, "R9 ft denied", int'(wdIrq), 0);
    end
    wrReg(8'hFC);            // steer reset: ft passes
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ftWave = i[0];
      @(negedge clk);
      check(wdIrq == ftWave, "R9 ft pass steer", int'(wdIrq), int'(ftWave));
    end
    wrReg(8'h00);
    ftActive = 1'b0;
    @(negedge clk);
    check(!wdIrq, "R9 idle line", int'(wdIrq), 0);

    // R2/R3 random configurations with restarts
    for (int it = 0; it < 24; it++) begin
      logic [7:0] cfg;
      int lim;
      int pre;
      cfg = {1'b0, 5'($urandom_range(1, 3)), 2'($urandom_range(0, 1))};
      lim = expTicks(cfg);
      wrReg(cfg);
      pre = $urandom_range(0, lim - 1);
      ticks(pre);
      rdReg();
      ticks(lim - 1);
      check(!wdFlag, "R3 random early", int'(wdFlag), 0);
      ticks(1);
      check(wdFlag, "R2 random expiry", int'(wdFlag), 1);
      rdFlag();
    end
    wrReg(8'h00);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule